// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block runs the byte-program and block-erase operations that a flash command front end hands to it. A program request carries a byte address and a data byte. The sequencer issues one write strobe to the array and waits a programmable number of cycles. It then reads the byte back and checks that every bit meant to go to 0 did go to 0. An erase request carries any address inside the target block. The sequencer issues one erase strobe and waits a duration that depends on the kind of block hit. The result is reported as ready, suspended, program-error, erase-error and low-voltage flags, which feed a status register kept elsewhere.

The address space holds four blocks: a 112 KB main block, two 4 KB parameter blocks and an 8 KB boot block. A parameter places the boot block at the top or at the bottom of the map. Writing or erasing the boot block needs a separate unlock input. The programming-voltage indication is sampled once, at the moment an operation is accepted. A running erase can be asked to pause. It stops at its next internal checkpoint, which falls every `CHK_CYC` cycles of erase time, and it continues from that point when resumed. While it is paused, reads are permitted from every block except the one being erased. Pulling the asynchronous reset low abandons whatever is running at once.

Top module: `flash_pe_seq`

## Requirements
- R1: With `BOOT_AT_TOP=1` the 17-bit map is: main 0x00000-0x1BFFF, parameter A 0x1C000-0x1CFFF, parameter B 0x1D000-0x1DFFF, boot 0x1E000-0x1FFFF. With `BOOT_AT_TOP=0` the order runs from address 0 as boot, parameter A, parameter B, main.
- R2: An accepted program request produces exactly one `arr_we_o` pulse carrying the address and data, and `ready_o` stays low for `PROG_CYC+1` cycles.
- R3: After the program wait the byte is read back, and `prog_err_o` is set only if a read-back bit is 1 where the data bit was 0. A location already programmed accepts new data that has 1s over its 0s without error.
- R4: An accepted erase request produces exactly one `arr_erase_o` pulse with the block address. `ready_o` stays low for `ER_MAIN_CYC`, `ER_PAR_CYC` or `ER_BOOT_CYC` cycles, chosen by the target block.
- R5: A program or erase that targets the boot block while `boot_unlock_i` is low sets `prog_err_o` or `erase_err_o` respectively, issues no array strobe and leaves `ready_o` high.
- R6: A request accepted while `vpp_ok_i` is low sets `vpp_low_o` and the error flag of the requested operation, and issues no array strobe.
- R7: While `vpp_low_o` is 1, program and erase requests are ignored: no strobe, and no change to any flag.
- R8: A suspend request during erase takes effect at the next checkpoint (every `CHK_CYC` erase cycles counted from the start). `ready_o` and `susp_o` then both go to 1. Time spent suspended does not count toward the erase duration.
- R9: A resume while suspended drops `ready_o` and `susp_o` on the next cycle, and the erase finishes its remaining cycles.
- R10: While suspended, `rd_ok_o` is 0 for addresses in the block being erased and 1 for all other addresses. When idle it is 1, and during an operation it is 0.
- R11: Requests arriving while busy or suspended are ignored, and a suspend request during a program has no effect.
- R12: The error and low-voltage flags stay set until `clr_status_i` is pulsed.
- R13: Reset low returns the block to ready with all flags clear at once. The array is left as it was, and no further strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset and abort |
| prog_req_i | input | 1 | Start a byte program (wins over erase) |
| erase_req_i | input | 1 | Start a block erase |
| op_addr_i | input | ADDR_W | Byte address, or any address inside the block to erase |
| op_data_i | input | DATA_W | Data byte to program |
| suspend_i | input | 1 | Ask a running erase to pause |
| resume_i | input | 1 | Continue a paused erase |
| clr_status_i | input | 1 | Clear the error and low-voltage flags |
| vpp_ok_i | input | 1 | Programming voltage present |
| boot_unlock_i | input | 1 | Permit boot-block program and erase |
| rd_addr_i | input | ADDR_W | Address of a read the front end wants to make |
| rd_ok_o | output | 1 | The read at rd_addr_i is permitted |
| arr_addr_o | output | ADDR_W | Array address for strobe and read-back |
| arr_wdata_o | output | DATA_W | Array write data |
| arr_we_o | output | 1 | One-cycle byte write strobe |
| arr_erase_o | output | 1 | One-cycle block erase strobe |
| arr_rdata_i | input | DATA_W | Array read-back data at arr_addr_o |
| ready_o | output | 1 | No operation running (also high while suspended) |
| susp_o | output | 1 | Erase is paused |
| prog_err_o | output | 1 | Program failed or was refused |
| erase_err_o | output | 1 | Erase was refused |
| vpp_low_o | output | 1 | Programming voltage was low at start |

## Verification
The bench aims at timing at the edges. It checks the exact busy length of each operation type, the suspend landing on the checkpoint rather than on the request, and the remaining erase time after a resume. A design that suspended immediately, or restarted its count on resume, would be caught by the cycle counts. Blocked starts are covered for the boot lock, the low-voltage case and the sticky low-voltage flag. These are checked at the array strobes, so a refused request that still pulsed the array fails. The bench also programs over an already-programmed byte and forces a byte that will not clear. A verify that compared for equality, or ignored the cleared bits, would flag or miss the wrong case. Reads during suspension are probed at block edges, where an off-by-one decode would allow a read inside the block being erased.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {
    BLK_MAIN = 2'd0,
    BLK_PARA = 2'd1,
    BLK_PARB = 2'd2,
    BLK_BOOT = 2'd3
  } blk_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_VERIFY = 3'd2,
    ST_ERASE  = 3'd3,
    ST_SUSP   = 3'd4
  } st_e;

endpackage

// File: rtl/flash_pe_blk_dec.sv
module flash_pe_blk_dec import flash_pe_pkg::*; #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned BOOT_W      = 13,
  parameter int unsigned PAR_W       = 12,
  parameter bit          BOOT_AT_TOP = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output blk_e              blk_o
);

  localparam logic [ADDR_W:0] TOTAL_L = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] BOOT_L  = (ADDR_W+1)'(1) << BOOT_W;
  localparam logic [ADDR_W:0] PAR_L   = (ADDR_W+1)'(1) << PAR_W;

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};

  generate
    if (BOOT_AT_TOP) begin : g_top
      localparam logic [ADDR_W:0] LO_BOOT = TOTAL_L - BOOT_L;
      localparam logic [ADDR_W:0] LO_PARB = LO_BOOT - PAR_L;
      localparam logic [ADDR_W:0] LO_PARA = LO_PARB - PAR_L;
      always_comb begin
        if (addr_x >= LO_BOOT)      blk_o = BLK_BOOT;
        else if (addr_x >= LO_PARB) blk_o = BLK_PARB;
        else if (addr_x >= LO_PARA) blk_o = BLK_PARA;
        else                        blk_o = BLK_MAIN;
      end
    end else begin : g_bot
      localparam logic [ADDR_W:0] END_BOOT = BOOT_L;
      localparam logic [ADDR_W:0] END_PARA = END_BOOT + PAR_L;
      localparam logic [ADDR_W:0] END_PARB = END_PARA + PAR_L;
      always_comb begin
        if (addr_x < END_BOOT)      blk_o = BLK_BOOT;
        else if (addr_x < END_PARA) blk_o = BLK_PARA;
        else if (addr_x < END_PARB) blk_o = BLK_PARB;
        else                        blk_o = BLK_MAIN;
      end
    end
  endgenerate

endmodule

// File: rtl/flash_pe_ctr.sv
module flash_pe_ctr #(
  parameter int unsigned CNT_W   = 22,
  parameter int unsigned CHK_CYC = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             run_i,
  output logic             done_o,
  output logic             chk_o
);

  localparam int unsigned CHK_W = (CHK_CYC > 1) ? $clog2(CHK_CYC) : 1;
  localparam logic [CHK_W-1:0] CHK_TOP = CHK_W'(CHK_CYC - 1);

  logic [CNT_W-1:0] rem_q;
  logic [CHK_W-1:0] chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      chk_q <= CHK_TOP;
    end else if (load_i) begin
      rem_q <= dur_i - CNT_W'(1);
      chk_q <= CHK_TOP;
    end else if (run_i && rem_q != '0) begin
      rem_q <= rem_q - CNT_W'(1);
      chk_q <= (chk_q == '0) ? CHK_TOP : chk_q - CHK_W'(1);
    end
  end

  assign done_o = (rem_q == '0);
  assign chk_o  = (chk_q == '0);

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq import flash_pe_pkg::*; #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BOOT_W      = 13,
  parameter int unsigned PAR_W       = 12,
  parameter bit          BOOT_AT_TOP = 1'b1,
  parameter int unsigned PROG_CYC    = 1500,
  parameter int unsigned ER_BOOT_CYC = 1300000,
  parameter int unsigned ER_PAR_CYC  = 1300000,
  parameter int unsigned ER_MAIN_CYC = 3000000,
  parameter int unsigned CHK_CYC     = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_req_i,
  input  logic              erase_req_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              clr_status_i,
  input  logic              vpp_ok_i,
  input  logic              boot_unlock_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ok_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              arr_we_o,
  output logic              arr_erase_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              ready_o,
  output logic              susp_o,
  output logic              prog_err_o,
  output logic              erase_err_o,
  output logic              vpp_low_o
);

  localparam int unsigned MAX_A   = (PROG_CYC > ER_BOOT_CYC) ? PROG_CYC : ER_BOOT_CYC;
  localparam int unsigned MAX_B   = (ER_PAR_CYC > ER_MAIN_CYC) ? ER_PAR_CYC : ER_MAIN_CYC;
  localparam int unsigned MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

  st_e               state_q;
  blk_e              blk_q, req_blk, rd_blk;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              we_q, er_q, pend_q;
  logic              perr_q, eerr_q, vlow_q;
  logic              accept, locked, go;
  logic              ctr_done, ctr_chk, ctr_run;
  logic [CNT_W-1:0]  dur;

  flash_pe_blk_dec #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PAR_W(PAR_W), .BOOT_AT_TOP(BOOT_AT_TOP)
  ) u_dec_op (
    .addr_i(op_addr_i),
    .blk_o (req_blk)
  );

  flash_pe_blk_dec #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PAR_W(PAR_W), .BOOT_AT_TOP(BOOT_AT_TOP)
  ) u_dec_rd (
    .addr_i(rd_addr_i),
    .blk_o (rd_blk)
  );

  // requests only count from idle with a clean voltage flag; program wins
  assign accept = (state_q == ST_IDLE) && !vlow_q && (prog_req_i || erase_req_i);
  assign locked = (req_blk == BLK_BOOT) && !boot_unlock_i;
  assign go     = accept && vpp_ok_i && !locked;

  always_comb begin
    if (prog_req_i) dur = CNT_W'(PROG_CYC);
    else begin
      case (req_blk)
        BLK_BOOT:           dur = CNT_W'(ER_BOOT_CYC);
        BLK_PARA, BLK_PARB: dur = CNT_W'(ER_PAR_CYC);
        default:            dur = CNT_W'(ER_MAIN_CYC);
      endcase
    end
  end

  assign ctr_run = (state_q == ST_PROG) || (state_q == ST_ERASE);

  flash_pe_ctr #(
    .CNT_W(CNT_W), .CHK_CYC(CHK_CYC)
  ) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(go),
    .dur_i (dur),
    .run_i (ctr_run),
    .done_o(ctr_done),
    .chk_o (ctr_chk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= BLK_MAIN;
      addr_q  <= '0;
      data_q  <= '1;
      we_q    <= 1'b0;
      er_q    <= 1'b0;
      pend_q  <= 1'b0;
      perr_q  <= 1'b0;
      eerr_q  <= 1'b0;
      vlow_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      er_q <= 1'b0;
      if (clr_status_i) begin
        perr_q <= 1'b0;
        eerr_q <= 1'b0;
        vlow_q <= 1'b0;
      end
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!vpp_ok_i) begin
              vlow_q <= 1'b1;
              if (prog_req_i) perr_q <= 1'b1;
              else            eerr_q <= 1'b1;
            end else if (locked) begin
              if (prog_req_i) perr_q <= 1'b1;
              else            eerr_q <= 1'b1;
            end else begin
              addr_q <= op_addr_i;
              blk_q  <= req_blk;
              pend_q <= 1'b0;
              if (prog_req_i) begin
                data_q  <= op_data_i;
                we_q    <= 1'b1;
                state_q <= ST_PROG;
              end else begin
                data_q  <= '1;
                er_q    <= 1'b1;
                state_q <= ST_ERASE;
              end
            end
          end
        end
        ST_PROG: if (ctr_done) state_q <= ST_VERIFY;
        ST_VERIFY: begin
          // only a bit that should have cleared but reads 1 is a failure
          if ((arr_rdata_i & ~data_q) != '0) perr_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_ERASE: begin
          if (suspend_i) pend_q <= 1'b1;
          if (ctr_done) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
          end else if (ctr_chk && (pend_q || suspend_i)) begin
            state_q <= ST_SUSP;
            pend_q  <= 1'b0;
          end
        end
        ST_SUSP: if (resume_i) state_q <= ST_ERASE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_IDLE: rd_ok_o = 1'b1;
      ST_SUSP: rd_ok_o = (rd_blk != blk_q);
      default: rd_ok_o = 1'b0;
    endcase
  end

  assign ready_o     = (state_q == ST_IDLE) || (state_q == ST_SUSP);
  assign susp_o      = (state_q == ST_SUSP);
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = data_q;
  assign arr_we_o    = we_q;
  assign arr_erase_o = er_q;
  assign prog_err_o  = perr_q;
  assign erase_err_o = eerr_q;
  assign vpp_low_o   = vlow_q;

  AST_BOOT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !susp_o && prog_req_i && req_blk == BLK_BOOT && !boot_unlock_i) |=> !arr_we_o); // R5
  AST_VPP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !susp_o && !vpp_low_o && prog_req_i && !vpp_ok_i) |=> (vpp_low_o && prog_err_o && !arr_we_o)); // R6
  AST_VPP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_low_o |=> !(arr_we_o || arr_erase_o)); // R7
  AST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_o && resume_i) |=> (!ready_o && !susp_o)); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o || susp_o) |=> !(arr_we_o || arr_erase_o)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_err_o && !clr_status_i) |=> prog_err_o); // R12
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arr_we_o, arr_erase_o})); // R2

endmodule

// File: tb/flash_pe_seq_tb.sv
`timescale 1ns/1ps
module flash_pe_seq_tb;

  localparam int PROG = 8, EBOOT = 48, EPAR = 32, EMAIN = 64, CHK = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        prog_req = 0, erase_req = 0, suspend = 0, resume = 0, clr_status = 0;
  logic        vpp_ok = 1, boot_unlock = 0;
  logic [16:0] op_addr = '0, rd_addr = '0, arr_addr;
  logic [7:0]  op_data = '0, arr_wdata, arr_rdata = 8'hFF;
  logic        rd_ok, arr_we, arr_erase, ready, susp, prog_err, erase_err, vpp_low;

  int checks = 0, errors = 0, we_cnt = 0, er_cnt = 0, stuck_addr = -1;
  bit finished = 0;
  logic [7:0] mem [int];

  always #5 clk = ~clk;

  flash_pe_seq #(
    .PROG_CYC(PROG), .ER_BOOT_CYC(EBOOT), .ER_PAR_CYC(EPAR),
    .ER_MAIN_CYC(EMAIN), .CHK_CYC(CHK)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_req_i(prog_req), .erase_req_i(erase_req),
    .op_addr_i(op_addr), .op_data_i(op_data), .suspend_i(suspend), .resume_i(resume),
    .clr_status_i(clr_status), .vpp_ok_i(vpp_ok), .boot_unlock_i(boot_unlock),
    .rd_addr_i(rd_addr), .rd_ok_o(rd_ok), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
    .arr_we_o(arr_we), .arr_erase_o(arr_erase), .arr_rdata_i(arr_rdata),
    .ready_o(ready), .susp_o(susp), .prog_err_o(prog_err), .erase_err_o(erase_err),
    .vpp_low_o(vpp_low)
  );

  // block range per R1, boot at top
  function automatic int blk_lo(int a);
    if (a >= 'h1E000) return 'h1E000;
    if (a >= 'h1D000) return 'h1D000;
    if (a >= 'h1C000) return 'h1C000;
    return 0;
  endfunction
  function automatic int blk_hi(int a);
    if (a >= 'h1E000) return 'h1FFFF;
    if (a >= 'h1D000) return 'h1DFFF;
    if (a >= 'h1C000) return 'h1CFFF;
    return 'h1BFFF;
  endfunction
  function automatic logic [7:0] rd_mem(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (arr_we) begin
      we_cnt++;
      if (int'(arr_addr) != stuck_addr) mem[int'(arr_addr)] = rd_mem(int'(arr_addr)) & arr_wdata;
    end
    if (arr_erase) begin
      int keys[$];
      int lo, hi;
      er_cnt++;
      lo = blk_lo(int'(arr_addr));
      hi = blk_hi(int'(arr_addr));
      foreach (mem[k]) if (k >= lo && k <= hi) keys.push_back(k);
      foreach (keys[i]) mem.delete(keys[i]);
    end
  end
  always @(negedge clk) arr_rdata = rd_mem(int'(arr_addr));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit prog, input int addr, input logic [7:0] data);
    @(negedge clk);
    prog_req = prog; erase_req = !prog; op_addr = addr[16:0]; op_data = data;
    @(negedge clk);
    prog_req = 0; erase_req = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic clear_status();
    @(negedge clk); clr_status = 1;
    @(negedge clk); clr_status = 0;
  endtask

  task automatic t_reset_state();
    chk("R13", "ready after reset", ready, 1);
    chk("R13", "flags after reset", {susp, prog_err, erase_err, vpp_low}, 0);
    chk("R10", "rd_ok idle", rd_ok, 1);
  endtask

  task automatic t_program();
    int n, w0;
    w0 = we_cnt;
    issue(1, 'h00100, 8'hA5);
    chk("R10", "rd_ok while programming", rd_ok, 0);
    wait_ready(n);
    chk("R2", "program busy cycles", n, PROG + 1);
    chk("R2", "write strobes", we_cnt - w0, 1);
    chk("R2", "stored byte", rd_mem('h100), 'hA5);
    chk("R3", "no error on clean program", prog_err, 0);
    issue(1, 'h00100, 8'h5A);
    wait_ready(n);
    chk("R3", "AND of old and new", rd_mem('h100), 'h00);
    chk("R3", "ones over zeros not an error", prog_err, 0);
  endtask

  task automatic t_verify_fail();
    int n;
    stuck_addr = 'h00300;
    issue(1, 'h00300, 8'h00);
    wait_ready(n);
    chk("R3", "stuck bits flagged", prog_err, 1);
    issue(1, 'h00310, 8'h33);
    wait_ready(n);
    chk("R12", "error sticky over good program", prog_err, 1);
    clear_status();
    chk("R12", "error cleared", prog_err, 0);
    stuck_addr = -1;
  endtask

  task automatic t_erase();
    int n, e0;
    e0 = er_cnt;
    issue(1, 'h1C020, 8'h11);
    wait_ready(n);
    issue(0, 'h1C7FF, 8'h00);
    wait_ready(n);
    chk("R4", "parameter erase cycles", n, EPAR);
    chk("R4", "parameter byte erased", rd_mem('h1C020), 'hFF);
    issue(0, 'h00100, 8'h00);
    wait_ready(n);
    chk("R4", "main erase cycles", n, EMAIN);
    chk("R4", "main byte erased", rd_mem('h100), 'hFF);
    boot_unlock = 1;
    issue(0, 'h1F000, 8'h00);
    wait_ready(n);
    boot_unlock = 0;
    chk("R4", "boot erase cycles", n, EBOOT);
    chk("R4", "erase strobes", er_cnt - e0, 3);
    chk("R4", "no erase error", erase_err, 0);
  endtask

  task automatic t_boot_lock();
    int n, w0, e0;
    w0 = we_cnt; e0 = er_cnt;
    issue(1, 'h1E000, 8'h00);
    chk("R5", "locked program ready", ready, 1);
    chk("R5", "locked program error", prog_err, 1);
    chk("R5", "locked program no strobe", we_cnt - w0, 0);
    clear_status();
    issue(0, 'h1FFFF, 8'h00);
    chk("R5", "locked erase error", {erase_err, prog_err}, 2'b10);
    chk("R5", "locked erase no strobe", er_cnt - e0, 0);
    clear_status();
    issue(1, 'h1DFFF, 8'h0F);
    wait_ready(n);
    chk("R1", "last parameter byte not boot", {prog_err, rd_mem('h1DFFF)}, 'h00F);
  endtask

  task automatic t_vpp();
    int n, w0, e0;
    w0 = we_cnt; e0 = er_cnt;
    vpp_ok = 0;
    issue(0, 'h00800, 8'h00);
    chk("R6", "low voltage flags", {vpp_low, erase_err, prog_err}, 3'b110);
    chk("R6", "no erase strobe", er_cnt - e0, 0);
    vpp_ok = 1;
    issue(1, 'h00800, 8'h00);
    @(negedge clk);
    chk("R7", "request ignored", {ready, prog_err, we_cnt - w0}, {1'b1, 1'b0, 32'd0});
    clear_status();
    chk("R12", "vpp flag cleared", {vpp_low, erase_err}, 0);
    issue(1, 'h00800, 8'h77);
    wait_ready(n);
    chk("R7", "program after clear", {we_cnt - w0, rd_mem('h800)}, {32'd1, 8'h77});
  endtask

  task automatic t_suspend();
    int n, w0;
    issue(0, 'h1C000, 8'h00);
    suspend = 1;
    @(negedge clk);
    suspend = 0;
    wait_ready(n);
    chk("R8", "suspend lands on checkpoint", n + 1, CHK);
    chk("R8", "suspended flags", {ready, susp}, 2'b11);
    rd_addr = 'h1C010; #1;
    chk("R10", "read in erased block blocked", rd_ok, 0);
    rd_addr = 'h1D000; #1;
    chk("R10", "read next block ok", rd_ok, 1);
    rd_addr = 'h1BFFF; #1;
    chk("R1", "main top byte readable", rd_ok, 1);
    w0 = we_cnt;
    issue(1, 'h00900, 8'h00);
    chk("R11", "program while suspended ignored", {we_cnt - w0, susp}, {32'd0, 1'b1});
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    chk("R9", "resume drops flags", {ready, susp}, 2'b00);
    wait_ready(n);
    chk("R9", "remaining erase cycles", n, EPAR - CHK);
    chk("R9", "not suspended at end", susp, 0);
  endtask

  task automatic t_busy_ignore();
    int n, w0, e0;
    w0 = we_cnt;
    issue(1, 'h00A00, 8'h12);
    suspend = 1;
    @(negedge clk);
    suspend = 0;
    wait_ready(n);
    chk("R11", "suspend ignored in program", {n + 1, susp}, {PROG + 1, 1'b0});
    e0 = er_cnt;
    issue(0, 'h00400, 8'h00);
    issue(1, 'h00500, 8'h00);
    wait_ready(n);
    chk("R11", "program during erase ignored", {we_cnt - w0, er_cnt - e0}, {32'd1, 32'd1});
    chk("R11", "byte untouched", rd_mem('h500), 'hFF);
  endtask

  task automatic t_abort();
    int e0;
    issue(1, 'h00600, 8'h12);
    repeat (PROG + 3) @(negedge clk);
    e0 = er_cnt;
    issue(0, 'h00600, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 0; #1;
    chk("R13", "ready at once on abort", {ready, susp, erase_err}, 3'b100);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (EMAIN + 8) @(negedge clk);
    chk("R13", "no strobe after abort", er_cnt - e0, 1);
    chk("R13", "array left partly erased", rd_mem('h600), 'hFF);
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_program();
    t_verify_fail();
    t_erase();
    t_boot_lock();
    t_vpp();
    t_suspend();
    t_busy_ignore();
    t_abort();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule